// File: doc/BRIEF.md
# Virtual Circuit Label Swapper

This block performs the per-hop header work of a virtual-circuit packet switch. It keeps a connection table addressed by the pair (input port, incoming circuit identifier). Each table entry holds an output port, an outgoing circuit identifier and a valid bit. A setup interface installs or tears down one entry per cycle, and a circuit must be installed before its packets arrive. Every arriving header presents its input port and circuit identifier. One cycle later the block returns the destination port and the replacement identifier, so the identifier changes at every hop. If the key has no valid entry, the block returns a drop flag instead.

The same identifier value arriving on two different ports resolves through two separate entries. Those entries may lead to different outputs or different outgoing identifiers. Headers may arrive on every cycle. Payload, signalling and queueing belong to the surrounding logic.

Top module: `vc_label_swap`

## Requirements
- R1: While `rst_n` is low, `res_valid` is low on the following cycle, and reset leaves every table entry invalid, so any header after reset is dropped.
- R2: A setup cycle with `cfg_valid` high and `cfg_op` = 2'b01 (install) stores (`cfg_out_port`, `cfg_out_vci`) as a valid entry for the key (`cfg_in_port`, `cfg_in_vci`).
- R3: `res_valid` is high exactly in the cycle after a cycle with `hdr_valid` high. For a key with a valid entry, `res_port` and `res_vci` carry that entry's output port and outgoing identifier and `res_drop` is low.
- R4: The key is the full pair: the same `hdr_vci` on different `hdr_port` values selects independent entries, e.g. (1,1)->(3,1) and (2,1)->(3,2) coexist.
- R5: A header whose key has no valid entry yields `res_drop` high with `res_port` and `res_vci` both zero.
- R6: A setup cycle with `cfg_op` = 2'b10 (remove) invalidates only the addressed entry; later headers to that key are dropped and other entries are unchanged.
- R7: Installing on a key that already holds a valid entry replaces its output port and outgoing identifier.
- R8: Setup cycles with `cfg_op` = 2'b00 or 2'b11 change no entry.
- R9: Headers presented on consecutive cycles each get their own result, one cycle later, in order.
- R10: When a setup and a header for the same key fall in the same cycle, the header is resolved against the table contents from before that setup; the change applies from the next cycle.
- R11: The extreme keys (port 0, identifier 0) and (last port, last identifier) are distinct, fully usable entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Setup command present this cycle |
| cfg_op | input | 2 | Setup operation: 01 install, 10 remove, others no operation |
| cfg_in_port | input | log2(NUM_PORTS) | Input port of the key being set up |
| cfg_in_vci | input | VCI_W | Incoming identifier of the key being set up |
| cfg_out_port | input | log2(NUM_PORTS) | Output port to store (install only) |
| cfg_out_vci | input | VCI_W | Outgoing identifier to store (install only) |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_port | input | log2(NUM_PORTS) | Input port the header arrived on |
| hdr_vci | input | VCI_W | Circuit identifier carried by the header |
| res_valid | output | 1 | Result for the header of the previous cycle |
| res_drop | output | 1 | Previous header had no valid entry |
| res_port | output | log2(NUM_PORTS) | Destination port (zero on drop) |
| res_vci | output | VCI_W | Replacement identifier (zero on drop) |

## Verification
The bench builds the block with its defaults: four ports and a four-bit identifier, which gives a 64-entry table. At this size both extreme keys and the shared-identifier-across-ports case can be reached directly with a handful of setups. The bench also covers overwrite, teardown, no-operation codes, back-to-back headers and the same-cycle setup/lookup ordering, and compares every result against expected values written into its vector table.

// File: rtl/vcs_pkg.sv
// Shared definitions for the virtual-circuit label swapper.
// Assumes: setup operation is carried on a two-bit field.
package vcs_pkg;

    typedef enum logic [1:0] {
        CFG_NOP0    = 2'b00,
        CFG_INSTALL = 2'b01,
        CFG_REMOVE  = 2'b10,
        CFG_NOP3    = 2'b11
    } cfg_op_e;

endpackage

// File: rtl/vcs_key_index.sv
// Flattens a (port, identifier) key into a table index.
// Assumes: port count is a power of two, so the index space is dense.
module vcs_key_index #(
    parameter int PORT_W = 2,
    parameter int VCI_W  = 4,
    localparam int IDX_W = PORT_W + VCI_W
) (
    input  logic [PORT_W-1:0] port,
    input  logic [VCI_W-1:0]  vci,
    output logic [IDX_W-1:0]  idx
);

    // Port selects the upper index bits, identifier the lower ones.
    always_comb begin
        idx = {port, vci};
    end

endmodule

// File: rtl/vcs_conn_table.sv
// Direct-indexed connection table: one valid bit and one payload per key.
// Assumes: at most one write (set or clear) per cycle; reads are
// combinational and see the contents from before the current edge.
module vcs_conn_table #(
    parameter int IDX_W   = 6,
    parameter int ENTRY_W = 6,
    localparam int DEPTH  = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_set,
    input  logic               wr_clr,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_hit,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [DEPTH-1:0]   valid_q;
    logic [ENTRY_W-1:0] mem_q [DEPTH];

    // One valid flop per entry, cleared by reset.
    for (genvar i = 0; i < DEPTH; i++) begin : g_valid
        always_ff @(posedge clk) begin
            // Track install and teardown of entry i.
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
            end else if (wr_set && (wr_idx == IDX_W'(i))) begin
                valid_q[i] <= 1'b1;
            end else if (wr_clr && (wr_idx == IDX_W'(i))) begin
                valid_q[i] <= 1'b0;
            end
        end
    end

    // Payload storage; meaningful only where the valid bit is set.
    always_ff @(posedge clk) begin
        if (rst_n && wr_set) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // Combinational read of the pre-edge contents.
    always_comb begin
        rd_hit  = valid_q[rd_idx];
        rd_data = mem_q[rd_idx];
    end

endmodule

// File: rtl/vcs_result_reg.sv
// Registers one lookup result per header; zeroes the fields on a miss.
// Assumes: lookup data is valid in the same cycle as hdr_valid.
module vcs_result_reg #(
    parameter int ENTRY_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hdr_valid,
    input  logic               hit,
    input  logic [ENTRY_W-1:0] entry,
    output logic               res_valid,
    output logic               res_drop,
    output logic [ENTRY_W-1:0] res_entry
);

    // Capture valid, drop flag and rewritten header fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_drop  <= 1'b0;
            res_entry <= '0;
        end else begin
            res_valid <= hdr_valid;
            res_drop  <= hdr_valid && !hit;
            res_entry <= (hdr_valid && hit) ? entry : '0;
        end
    end

endmodule

// File: rtl/vc_label_swap.sv
// Per-hop virtual-circuit forwarding: looks up (port, identifier) and
// returns (output port, new identifier) one cycle later, or a drop flag.
// Assumes: NUM_PORTS is a power of two of at least 2; one setup per cycle.
module vc_label_swap #(
    parameter int NUM_PORTS = 4,
    parameter int VCI_W     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_valid,
    input  logic [1:0]                   cfg_op,
    input  logic [$clog2(NUM_PORTS)-1:0] cfg_in_port,
    input  logic [VCI_W-1:0]             cfg_in_vci,
    input  logic [$clog2(NUM_PORTS)-1:0] cfg_out_port,
    input  logic [VCI_W-1:0]             cfg_out_vci,
    input  logic                         hdr_valid,
    input  logic [$clog2(NUM_PORTS)-1:0] hdr_port,
    input  logic [VCI_W-1:0]             hdr_vci,
    output logic                         res_valid,
    output logic                         res_drop,
    output logic [$clog2(NUM_PORTS)-1:0] res_port,
    output logic [VCI_W-1:0]             res_vci
);
    import vcs_pkg::*;

    localparam int PORT_W  = $clog2(NUM_PORTS);
    localparam int IDX_W   = PORT_W + VCI_W;
    localparam int ENTRY_W = PORT_W + VCI_W;

    cfg_op_e            op;
    logic               do_set;
    logic               do_clr;
    logic [IDX_W-1:0]   cfg_idx;
    logic [IDX_W-1:0]   hdr_idx;
    logic               tbl_hit;
    logic [ENTRY_W-1:0] tbl_entry;
    logic [ENTRY_W-1:0] out_entry;

    // Decode the setup command into set and clear strobes.
    always_comb begin
        op     = cfg_op_e'(cfg_op);
        do_set = cfg_valid && (op == CFG_INSTALL);
        do_clr = cfg_valid && (op == CFG_REMOVE);
    end

    vcs_key_index #(.PORT_W(PORT_W), .VCI_W(VCI_W)) u_cfg_key (
        .port (cfg_in_port),
        .vci  (cfg_in_vci),
        .idx  (cfg_idx)
    );

    vcs_key_index #(.PORT_W(PORT_W), .VCI_W(VCI_W)) u_hdr_key (
        .port (hdr_port),
        .vci  (hdr_vci),
        .idx  (hdr_idx)
    );

    vcs_conn_table #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_set  (do_set),
        .wr_clr  (do_clr),
        .wr_idx  (cfg_idx),
        .wr_data ({cfg_out_port, cfg_out_vci}),
        .rd_idx  (hdr_idx),
        .rd_hit  (tbl_hit),
        .rd_data (tbl_entry)
    );

    vcs_result_reg #(.ENTRY_W(ENTRY_W)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_valid (hdr_valid),
        .hit       (tbl_hit),
        .entry     (tbl_entry),
        .res_valid (res_valid),
        .res_drop  (res_drop),
        .res_entry (out_entry)
    );

    // Split the registered entry back into port and identifier.
    always_comb begin
        res_port = out_entry[ENTRY_W-1:VCI_W];
        res_vci  = out_entry[VCI_W-1:0];
    end

endmodule

// File: rtl/vc_label_swap_chk.sv
// Temporal checks on the label swapper's ports, bound to every instance.
// Assumes: the bound instance uses the same parameter values.
module vc_label_swap_chk #(
    parameter int NUM_PORTS = 4,
    parameter int VCI_W     = 4,
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_valid,
    input logic [1:0]        cfg_op,
    input logic [PORT_W-1:0] cfg_in_port,
    input logic [VCI_W-1:0]  cfg_in_vci,
    input logic [PORT_W-1:0] cfg_out_port,
    input logic [VCI_W-1:0]  cfg_out_vci,
    input logic              hdr_valid,
    input logic [PORT_W-1:0] hdr_port,
    input logic [VCI_W-1:0]  hdr_vci,
    input logic              res_valid,
    input logic              res_drop,
    input logic [PORT_W-1:0] res_port,
    input logic [VCI_W-1:0]  res_vci
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !res_valid); // R1

    AST_RES_FOLLOWS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> res_valid); // R3

    AST_NO_SPURIOUS_RES: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !res_valid); // R3

    AST_DROP_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        res_drop |-> (res_valid && res_port == '0 && res_vci == '0)); // R5

    AST_INSTALL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && $past(rst_n) && $past(cfg_valid) && $past(cfg_op) == 2'b01
         && hdr_port == $past(cfg_in_port) && hdr_vci == $past(cfg_in_vci))
        |=> (!res_drop && res_port == $past(cfg_out_port, 2)
             && res_vci == $past(cfg_out_vci, 2))); // R2

    AST_REMOVE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && $past(rst_n) && $past(cfg_valid) && $past(cfg_op) == 2'b10
         && hdr_port == $past(cfg_in_port) && hdr_vci == $past(cfg_in_vci))
        |=> res_drop); // R6

endmodule

bind vc_label_swap vc_label_swap_chk #(.NUM_PORTS(NUM_PORTS), .VCI_W(VCI_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_valid    (cfg_valid),
    .cfg_op       (cfg_op),
    .cfg_in_port  (cfg_in_port),
    .cfg_in_vci   (cfg_in_vci),
    .cfg_out_port (cfg_out_port),
    .cfg_out_vci  (cfg_out_vci),
    .hdr_valid    (hdr_valid),
    .hdr_port     (hdr_port),
    .hdr_vci      (hdr_vci),
    .res_valid    (res_valid),
    .res_drop     (res_drop),
    .res_port     (res_port),
    .res_vci      (res_vci)
);

// File: tb/vc_label_swap_test.sv
`timescale 1ns/1ps
module vc_label_swap_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_valid = 1'b0;
    logic [1:0] cfg_op = 2'b00;
    logic [1:0] cfg_in_port = '0;
    logic [3:0] cfg_in_vci = '0;
    logic [1:0] cfg_out_port = '0;
    logic [3:0] cfg_out_vci = '0;
    logic       hdr_valid = 1'b0;
    logic [1:0] hdr_port = '0;
    logic [3:0] hdr_vci = '0;
    logic       res_valid;
    logic       res_drop;
    logic [1:0] res_port;
    logic [3:0] res_vci;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    vc_label_swap uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_op(cfg_op),
        .cfg_in_port(cfg_in_port), .cfg_in_vci(cfg_in_vci),
        .cfg_out_port(cfg_out_port), .cfg_out_vci(cfg_out_vci),
        .hdr_valid(hdr_valid), .hdr_port(hdr_port), .hdr_vci(hdr_vci),
        .res_valid(res_valid), .res_drop(res_drop),
        .res_port(res_port), .res_vci(res_vci)
    );

    // is_hdr, op, port, vci, out port, out vci, expected drop, requirement
    typedef struct packed {
        logic       is_hdr;
        logic [1:0] op;
        logic [1:0] p;
        logic [3:0] v;
        logic [1:0] op_port;
        logic [3:0] op_vci;
        logic       drop;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'b00, 2'd0, 4'd0,  2'd0, 4'd0,  1'b1, 4'd1},  // R1 empty after reset
        '{1'b0, 2'b01, 2'd1, 4'd1,  2'd3, 4'd1,  1'b0, 4'd2},  // R2 install
        '{1'b0, 2'b01, 2'd2, 4'd1,  2'd3, 4'd2,  1'b0, 4'd2},  // R2 install
        '{1'b1, 2'b00, 2'd1, 4'd1,  2'd3, 4'd1,  1'b0, 4'd4},  // R4
        '{1'b1, 2'b00, 2'd2, 4'd1,  2'd3, 4'd2,  1'b0, 4'd4},  // R4
        '{1'b1, 2'b00, 2'd3, 4'd1,  2'd0, 4'd0,  1'b1, 4'd5},  // R5 miss
        '{1'b0, 2'b01, 2'd3, 4'd15, 2'd0, 4'd9,  1'b0, 4'd2},
        '{1'b0, 2'b01, 2'd0, 4'd0,  2'd2, 4'd14, 1'b0, 4'd2},
        '{1'b1, 2'b00, 2'd3, 4'd15, 2'd0, 4'd9,  1'b0, 4'd11}, // R11
        '{1'b1, 2'b00, 2'd0, 4'd0,  2'd2, 4'd14, 1'b0, 4'd11}, // R11
        '{1'b0, 2'b11, 2'd1, 4'd1,  2'd0, 4'd0,  1'b0, 4'd8},  // R8 op 11
        '{1'b1, 2'b00, 2'd1, 4'd1,  2'd3, 4'd1,  1'b0, 4'd8},  // R8
        '{1'b0, 2'b00, 2'd2, 4'd1,  2'd1, 4'd5,  1'b0, 4'd8},  // R8 op 00
        '{1'b1, 2'b00, 2'd2, 4'd1,  2'd3, 4'd2,  1'b0, 4'd8},  // R8
        '{1'b0, 2'b01, 2'd1, 4'd1,  2'd2, 4'd7,  1'b0, 4'd7},  // R7 overwrite
        '{1'b1, 2'b00, 2'd1, 4'd1,  2'd2, 4'd7,  1'b0, 4'd7},  // R7
        '{1'b0, 2'b10, 2'd1, 4'd1,  2'd0, 4'd0,  1'b0, 4'd6},  // R6 remove
        '{1'b1, 2'b00, 2'd1, 4'd1,  2'd0, 4'd0,  1'b1, 4'd6},  // R6
        '{1'b1, 2'b00, 2'd2, 4'd1,  2'd3, 4'd2,  1'b0, 4'd6}   // R6 neighbour kept
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare the registered result against the expected tuple.
    task automatic check_res(input string req, input bit edrop, input int ep, input int ev);
        check(res_valid == 1'b1, req, int'(res_valid), 1);
        check(res_drop == edrop && int'(res_port) == ep && int'(res_vci) == ev, req,
              int'({res_drop, res_port, res_vci}), int'({edrop, 2'(ep), 4'(ev)}));
    endtask

    // Called at a negedge; returns at the next negedge.
    task automatic do_cfg(input logic [1:0] op, input int p, input int v, input int op_, input int ov);
        cfg_valid = 1'b1; cfg_op = op;
        cfg_in_port = 2'(p); cfg_in_vci = 4'(v);
        cfg_out_port = 2'(op_); cfg_out_vci = 4'(ov);
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic do_hdr(input string req, input int p, input int v, input bit edrop, input int ep, input int ev);
        hdr_valid = 1'b1; hdr_port = 2'(p); hdr_vci = 4'(v);
        @(negedge clk);
        hdr_valid = 1'b0;
        check_res(req, edrop, ep, ev);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i].req);
            if (VEC[i].is_hdr)
                do_hdr(rq, VEC[i].p, VEC[i].v, VEC[i].drop, VEC[i].op_port, VEC[i].op_vci);
            else
                do_cfg(VEC[i].op, VEC[i].p, VEC[i].v, VEC[i].op_port, VEC[i].op_vci);
        end

        // R3: no header, no result.
        @(negedge clk);
        check(res_valid == 1'b0, "R3", int'(res_valid), 0);

        // R9: three headers on consecutive cycles.
        hdr_valid = 1'b1; hdr_port = 2'd3; hdr_vci = 4'd15;
        @(negedge clk);
        check_res("R9", 1'b0, 0, 9);
        hdr_port = 2'd0; hdr_vci = 4'd0;
        @(negedge clk);
        check_res("R9", 1'b0, 2, 14);
        hdr_port = 2'd2; hdr_vci = 4'd1;
        @(negedge clk);
        check_res("R9", 1'b0, 3, 2);
        hdr_valid = 1'b0;
        @(negedge clk);

        // R10: setup and header to the same key in one cycle.
        cfg_valid = 1'b1; cfg_op = 2'b01; cfg_in_port = 2'd1; cfg_in_vci = 4'd2;
        cfg_out_port = 2'd1; cfg_out_vci = 4'd3;
        hdr_valid = 1'b1; hdr_port = 2'd1; hdr_vci = 4'd2;
        @(negedge clk);
        cfg_valid = 1'b0;
        check_res("R10", 1'b1, 0, 0);
        @(negedge clk);
        hdr_valid = 1'b0;
        check_res("R10", 1'b0, 1, 3);

        // R1: reset mid-run clears the table.
        rst_n = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b0, "R1", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_hdr("R1", 2, 1, 1'b1, 0, 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule